// File: doc/BRIEF.md
# Trap and Interrupt Entry Sequencer

This block steers a small processor core into and out of its exception handlers. It owns the processor status word. Five single-cycle request lines feed it: a non-maskable interrupt, a supervisor call, a trace trap, a maskable interrupt and a return-from-trap. When the sequencer is idle, it accepts the highest-priority request that is eligible. A request that is not accepted must be held by its requester until it is accepted.

On entry the block copies the status word, changes the flags that suit the event, and pushes two words onto an external stack. The saved status word goes first, then a return address. It then strobes a two-bit handler index for the vector fetch. Which return address is pushed depends on the event. A supervisor call pushes the address of the calling instruction. Every other entry pushes the address of the next instruction. On return the block pops the address, then the status word. It hands the address to the fetch unit and restores the flags, except the P flag, which keeps its current value.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the status word becomes all zero and the sequencer returns to idle. After reset, `busy_o`, `push_en_o`, `pop_en_o`, `vec_valid_o` and `pc_load_o` are low.
- R2: In an idle cycle at most one request is accepted, and `accept_o` shows it combinationally as a one-hot value. The bits of `accept_o` are: bit 0 non-maskable interrupt, bit 1 supervisor call, bit 2 trace trap, bit 3 maskable interrupt, bit 4 return-from-trap. Priority follows the same order, with bit 0 highest.
- R3: The status layout is T bit 0, P bit 1, S bit 2, U bit 3, I bit 4. While I is 0, a maskable interrupt request is not accepted and has no effect. A non-maskable request is accepted whatever the value of I.
- R4: A supervisor call pushes `cur_pc_i`. A trace trap and both interrupt kinds push `nxt_pc_i`. The value pushed is the one sampled in the accept cycle.
- R5: An entry lasts three cycles after the accept edge. In the first, the status word as it was before entry is pushed, zero-extended to the stack width. In the second, the return address is pushed. In the third, `vec_valid_o` is high. `busy_o` is high in all three cycles.
- R6: Handler indices are: 0 non-maskable interrupt, 1 maskable interrupt, 2 supervisor call, 3 trace trap.
- R7: Entry by either interrupt kind clears T, P, S, U and I at the accept edge.
- R8: A supervisor call or trace trap entry clears T, P, S and U and leaves I unchanged.
- R9: A return-from-trap pops for two cycles, first the address and then the status word. In the second pop cycle, `pc_load_o` is high and `pc_value_o` holds the popped address.
- R10: A return-from-trap loads T, S, U and I from the popped status word and keeps the current P. The block never changes status bits above bit 4.
- R11: While `busy_o` is high, no request is accepted, and a request that is dropped before the sequence ends leaves no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_nmi_i | input | 1 | Non-maskable interrupt request |
| req_svc_i | input | 1 | Supervisor call request |
| req_trc_i | input | 1 | Trace trap request |
| req_irq_i | input | 1 | Maskable interrupt request |
| req_rett_i | input | 1 | Return-from-trap request |
| cur_pc_i | input | AW | Address of the current instruction |
| nxt_pc_i | input | AW | Address of the next instruction |
| pop_data_i | input | AW | Word read from the stack top during a pop |
| accept_o | output | 5 | One-hot accepted request |
| busy_o | output | 1 | Entry or return sequence in progress |
| push_en_o | output | 1 | Stack push strobe |
| push_data_o | output | AW | Word to push |
| pop_en_o | output | 1 | Stack pop strobe |
| vec_valid_o | output | 1 | Handler index valid |
| vec_idx_o | output | 2 | Handler index |
| pc_load_o | output | 1 | Return address valid |
| pc_value_o | output | AW | Return address from the stack |
| psr_o | output | SW | Processor status word |

## Verification
The bench targets the return-address split by giving every event a different current and next address. A design that pushed the next address for a supervisor call would then resume one instruction too late. It pops a saved word with every bit set while P is clear. A restore that copied P, or that touched the upper bits, would then leave a status value other than 0x1D. It also checks the mask edge in both directions. With I clear, a maskable request must leave the stack pointer unchanged. A later return must bring I back to 1, while a non-maskable event is still taken with I clear. Finally, it raises a non-maskable request only during a busy sequence; a design that accepted it would push a second frame.

// File: rtl/trap_pkg.sv
package trap_pkg;
   localparam int unsigned FLAG_T  = 0;
   localparam int unsigned FLAG_P  = 1;
   localparam int unsigned FLAG_S  = 2;
   localparam int unsigned FLAG_U  = 3;
   localparam int unsigned FLAG_I  = 4;
   localparam int unsigned NUM_EVT = 5;

   typedef enum logic [2:0] {
      EV_NMI  = 3'd0,
      EV_SVC  = 3'd1,
      EV_TRC  = 3'd2,
      EV_IRQ  = 3'd3,
      EV_RETT = 3'd4
   } evt_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_PSR,
      ST_PUSH_PC,
      ST_VECTOR,
      ST_POP_PC,
      ST_POP_PSR
   } seq_e;

   function automatic logic [1:0] vec_of(evt_e e);
      case (e)
         EV_NMI:  return 2'd0;
         EV_IRQ:  return 2'd1;
         EV_SVC:  return 2'd2;
         default: return 2'd3;
      endcase
   endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_pkg::*;
#(
   parameter int unsigned NUM = NUM_EVT
) (
   input  logic [NUM-1:0] req_i,
   input  logic           idle_i,
   input  logic           irq_en_i,
   output logic [NUM-1:0] grant_o,
   output logic           any_o,
   output evt_e           evt_o
);
   logic [NUM-1:0] eligible;

   always_comb begin
      eligible = req_i;
      eligible[EV_IRQ] = req_i[EV_IRQ] & irq_en_i;
   end

   always_comb begin
      grant_o = '0;
      any_o   = 1'b0;
      evt_o   = EV_NMI;
      for (int k = 0; k < NUM; k++) begin
         if (!any_o && idle_i && eligible[k]) begin
            grant_o[k] = 1'b1;
            any_o      = 1'b1;
            evt_o      = evt_e'(3'(k));
         end
      end
   end
endmodule

// File: rtl/trap_psr_unit.sv
module trap_psr_unit
   import trap_pkg::*;
#(
   parameter int unsigned SW = 16,
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          take_int_i,
   input  logic          take_trap_i,
   input  logic          restore_i,
   input  logic [SW-1:0] restore_word_i,
   output logic [SW-1:0] psr_o,
   output logic [AW-1:0] saved_word_o
);
   localparam logic [SW-1:0] M_T = SW'(1) << FLAG_T;
   localparam logic [SW-1:0] M_P = SW'(1) << FLAG_P;
   localparam logic [SW-1:0] M_S = SW'(1) << FLAG_S;
   localparam logic [SW-1:0] M_U = SW'(1) << FLAG_U;
   localparam logic [SW-1:0] M_I = SW'(1) << FLAG_I;
   localparam logic [SW-1:0] TRAP_CLR = M_T | M_P | M_S | M_U;
   localparam logic [SW-1:0] INT_CLR  = TRAP_CLR | M_I;
   localparam logic [SW-1:0] RST_MASK = M_T | M_S | M_U | M_I;

   logic [SW-1:0] psr_q, saved_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         psr_q   <= '0;
         saved_q <= '0;
      end else if (take_int_i) begin
         saved_q <= psr_q;
         psr_q   <= psr_q & ~INT_CLR;
      end else if (take_trap_i) begin
         saved_q <= psr_q;
         psr_q   <= psr_q & ~TRAP_CLR;
      end else if (restore_i) begin
         psr_q   <= (psr_q & ~RST_MASK) | (restore_word_i & RST_MASK);
      end
   end

   assign psr_o = psr_q;

   generate
      if (AW > SW) begin : g_pad
         assign saved_word_o = {{(AW-SW){1'b0}}, saved_q};
      end else begin : g_same
         assign saved_word_o = saved_q;
      end
   endgenerate

   assert_int_clear_R7: assert property (@(posedge clk) disable iff (rst)
      take_int_i |=> (psr_o & INT_CLR) == '0);
   assert_trap_keeps_i_R8: assert property (@(posedge clk) disable iff (rst)
      take_trap_i |=> (psr_o[FLAG_I] == $past(psr_o[FLAG_I])) && ((psr_o & TRAP_CLR) == '0));
   assert_restore_keeps_p_R10: assert property (@(posedge clk) disable iff (rst)
      restore_i |=> (psr_o[FLAG_P] == $past(psr_o[FLAG_P]))
                    && (psr_o[FLAG_I] == $past(restore_word_i[FLAG_I])));
   assert_high_bits_stable_R10: assert property (@(posedge clk) disable iff (rst)
      $stable(psr_o[SW-1:FLAG_I+1]));
endmodule

// File: rtl/trap_seq.sv
module trap_seq
   import trap_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          any_i,
   input  evt_e          evt_i,
   input  logic [AW-1:0] cur_pc_i,
   input  logic [AW-1:0] nxt_pc_i,
   input  logic [AW-1:0] saved_word_i,
   input  logic [AW-1:0] pop_data_i,
   output logic          idle_o,
   output logic          busy_o,
   output logic          push_en_o,
   output logic [AW-1:0] push_data_o,
   output logic          pop_en_o,
   output logic          vec_valid_o,
   output logic [1:0]    vec_idx_o,
   output logic          pc_load_o,
   output logic [AW-1:0] pc_value_o,
   output logic          take_int_o,
   output logic          take_trap_o,
   output logic          restore_o
);
   seq_e          state_q;
   logic [AW-1:0] addr_q;
   logic [1:0]    vec_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         vec_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (any_i) begin
               vec_q   <= vec_of(evt_i);
               addr_q  <= (evt_i == EV_SVC) ? cur_pc_i : nxt_pc_i;
               state_q <= (evt_i == EV_RETT) ? ST_POP_PC : ST_PUSH_PSR;
            end
            ST_PUSH_PSR: state_q <= ST_PUSH_PC;
            ST_PUSH_PC:  state_q <= ST_VECTOR;
            ST_VECTOR:   state_q <= ST_IDLE;
            ST_POP_PC: begin
               addr_q  <= pop_data_i;
               state_q <= ST_POP_PSR;
            end
            default:     state_q <= ST_IDLE;
         endcase
      end
   end

   assign idle_o      = (state_q == ST_IDLE);
   assign busy_o      = !idle_o;
   assign push_en_o   = (state_q == ST_PUSH_PSR) || (state_q == ST_PUSH_PC);
   assign push_data_o = (state_q == ST_PUSH_PSR) ? saved_word_i : addr_q;
   assign pop_en_o    = (state_q == ST_POP_PC) || (state_q == ST_POP_PSR);
   assign vec_valid_o = (state_q == ST_VECTOR);
   assign vec_idx_o   = vec_q;
   assign pc_load_o   = (state_q == ST_POP_PSR);
   assign pc_value_o  = addr_q;
   assign restore_o   = (state_q == ST_POP_PSR);
   assign take_int_o  = any_i && ((evt_i == EV_NMI) || (evt_i == EV_IRQ));
   assign take_trap_o = any_i && ((evt_i == EV_SVC) || (evt_i == EV_TRC));

   assert_vec_after_pushes_R5: assert property (@(posedge clk) disable iff (rst)
      vec_valid_o |-> $past(push_en_o) && $past(busy_o));
   assert_vec_ends_seq_R5: assert property (@(posedge clk) disable iff (rst)
      vec_valid_o |=> !busy_o);
   assert_pc_after_pop_R9: assert property (@(posedge clk) disable iff (rst)
      pc_load_o |-> pop_en_o && $past(pop_en_o));
   assert_no_push_pop_R9: assert property (@(posedge clk) disable iff (rst)
      !(push_en_o && pop_en_o));
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
   import trap_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned SW = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               req_nmi_i,
   input  logic               req_svc_i,
   input  logic               req_trc_i,
   input  logic               req_irq_i,
   input  logic               req_rett_i,
   input  logic [AW-1:0]      cur_pc_i,
   input  logic [AW-1:0]      nxt_pc_i,
   input  logic [AW-1:0]      pop_data_i,
   output logic [NUM_EVT-1:0] accept_o,
   output logic               busy_o,
   output logic               push_en_o,
   output logic [AW-1:0]      push_data_o,
   output logic               pop_en_o,
   output logic               vec_valid_o,
   output logic [1:0]         vec_idx_o,
   output logic               pc_load_o,
   output logic [AW-1:0]      pc_value_o,
   output logic [SW-1:0]      psr_o
);
   generate
      if (SW <= FLAG_I) begin : g_bad_sw
         $error("status width must hold all five flags");
      end
      if (SW > AW) begin : g_bad_aw
         $error("status width must not exceed stack word width");
      end
   endgenerate

   logic [NUM_EVT-1:0] req_vec;
   logic               any, idle, take_int, take_trap, restore;
   evt_e               evt;
   logic [AW-1:0]      saved_word;

   always_comb begin
      req_vec          = '0;
      req_vec[EV_NMI]  = req_nmi_i;
      req_vec[EV_SVC]  = req_svc_i;
      req_vec[EV_TRC]  = req_trc_i;
      req_vec[EV_IRQ]  = req_irq_i;
      req_vec[EV_RETT] = req_rett_i;
   end

   trap_arbiter #(.NUM(NUM_EVT)) u_arb (
      .req_i(req_vec), .idle_i(idle), .irq_en_i(psr_o[FLAG_I]),
      .grant_o(accept_o), .any_o(any), .evt_o(evt)
   );

   trap_psr_unit #(.SW(SW), .AW(AW)) u_psr (
      .clk(clk), .rst(rst), .take_int_i(take_int), .take_trap_i(take_trap),
      .restore_i(restore), .restore_word_i(pop_data_i[SW-1:0]),
      .psr_o(psr_o), .saved_word_o(saved_word)
   );

   trap_seq #(.AW(AW)) u_seq (
      .clk(clk), .rst(rst), .any_i(any), .evt_i(evt),
      .cur_pc_i(cur_pc_i), .nxt_pc_i(nxt_pc_i), .saved_word_i(saved_word),
      .pop_data_i(pop_data_i), .idle_o(idle), .busy_o(busy_o),
      .push_en_o(push_en_o), .push_data_o(push_data_o), .pop_en_o(pop_en_o),
      .vec_valid_o(vec_valid_o), .vec_idx_o(vec_idx_o), .pc_load_o(pc_load_o),
      .pc_value_o(pc_value_o), .take_int_o(take_int), .take_trap_o(take_trap),
      .restore_o(restore)
   );

   assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (rst)
      busy_o |-> accept_o == '0);
   assert_irq_masked_R3: assert property (@(posedge clk) disable iff (rst)
      accept_o[EV_IRQ] |-> psr_o[FLAG_I]);
   assert_nmi_first_R2: assert property (@(posedge clk) disable iff (rst)
      (accept_o[EV_SVC] || accept_o[EV_TRC] || accept_o[EV_IRQ]) |-> !req_nmi_i);
   assert_one_accept_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot0(accept_o));
endmodule

// File: tb/tb_trap_entry_ctrl.sv
module tb_trap_entry_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int SW = 16;

   typedef struct packed {
      logic [4:0]  req;
      logic [4:0]  win;
      logic [31:0] cur;
      logic [31:0] nxt;
      logic [1:0]  vec;
      logic [31:0] addr;
      logic [15:0] saved;
      logic [15:0] psr_after;
   } row_t;

   // req/win bits: 0 nmi, 1 svc, 2 trace, 3 irq, 4 rett
   localparam row_t TABLE [6] = '{
      '{5'b00010, 5'b00010, 32'h100, 32'h104, 2'd2, 32'h100, 16'h001D, 16'h0010},
      '{5'b00100, 5'b00100, 32'h200, 32'h204, 2'd3, 32'h204, 16'h0010, 16'h0010},
      '{5'b01110, 5'b00010, 32'h300, 32'h304, 2'd2, 32'h300, 16'h0010, 16'h0010},
      '{5'b01100, 5'b00100, 32'h400, 32'h404, 2'd3, 32'h404, 16'h0010, 16'h0010},
      '{5'b01000, 5'b01000, 32'h500, 32'h504, 2'd1, 32'h504, 16'h0010, 16'h0000},
      '{5'b01111, 5'b00001, 32'h600, 32'h604, 2'd0, 32'h604, 16'h0000, 16'h0000}
   };

   logic clk = 0, rst = 1;
   logic req_nmi = 0, req_svc = 0, req_trc = 0, req_irq = 0, req_rett = 0;
   logic [AW-1:0] cur_pc = '0, nxt_pc = '0, pop_data = '0;
   logic [4:0] accept;
   logic busy, push_en, pop_en, vec_valid, pc_load;
   logic [AW-1:0] push_data, pc_value;
   logic [1:0] vec_idx;
   logic [SW-1:0] psr;

   int checks = 0, errors = 0;
   logic [31:0] mem [16];
   int sp = 0;
   int n_push = 0, n_vec = 0, n_pc = 0;
   logic [31:0] push_log [4];
   logic [1:0]  vec_log;
   logic [31:0] pc_log;

   always #(CLK_PERIOD/2) clk = ~clk;

   trap_entry_ctrl #(.AW(AW), .SW(SW)) dut (
      .clk(clk), .rst(rst), .req_nmi_i(req_nmi), .req_svc_i(req_svc),
      .req_trc_i(req_trc), .req_irq_i(req_irq), .req_rett_i(req_rett),
      .cur_pc_i(cur_pc), .nxt_pc_i(nxt_pc), .pop_data_i(pop_data),
      .accept_o(accept), .busy_o(busy), .push_en_o(push_en), .push_data_o(push_data),
      .pop_en_o(pop_en), .vec_valid_o(vec_valid), .vec_idx_o(vec_idx),
      .pc_load_o(pc_load), .pc_value_o(pc_value), .psr_o(psr)
   );

   // stack model and observation, all mid-cycle
   always @(negedge clk) begin
      if (push_en) begin
         mem[sp] = push_data;
         sp = sp + 1;
         if (n_push < 4) push_log[n_push] = push_data;
         n_push = n_push + 1;
      end
      if (pop_en) begin
         pop_data = mem[sp-1];
         sp = sp - 1;
      end
      if (vec_valid) begin
         vec_log = vec_idx;
         n_vec = n_vec + 1;
      end
      if (pc_load) begin
         pc_log = pc_value;
         n_pc = n_pc + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic set_reqs(input logic [4:0] r);
      req_nmi = r[0]; req_svc = r[1]; req_trc = r[2]; req_irq = r[3]; req_rett = r[4];
   endtask

   task automatic clear_logs();
      n_push = 0; n_vec = 0; n_pc = 0;
   endtask

   task automatic do_rett(input logic [31:0] exp_pc, input logic [15:0] exp_psr);
      int sp0;
      clear_logs();
      @(negedge clk);
      sp0 = sp;
      set_reqs(5'b10000);
      #1 chk("R2 rett accept", 32'(accept), 32'h10);
      @(negedge clk);
      set_reqs('0);
      repeat (2) @(negedge clk);
      chk("R9 pc_load count", n_pc, 1);
      chk("R9 popped address", pc_log, exp_pc);
      chk("R9 two words popped", sp0 - sp, 2);
      chk("R10 restored status", 32'(psr), 32'(exp_psr));
      chk("R9 no push on return", n_push, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      chk("R1 status after reset", 32'(psr), 0);
      chk("R1 idle after reset", {busy, push_en, pop_en, vec_valid, pc_load}, 0);

      // saved frame: status all ones below, address on top
      mem[0] = 32'h0000_FFFF;
      mem[1] = 32'h0000_0ABC;
      sp = 2;
      do_rett(32'h0ABC, 16'h001D);   // R10: P stays 0, upper bits stay 0

      foreach (TABLE[i]) begin
         int sp0;
         clear_logs();
         @(negedge clk);
         sp0 = sp;
         cur_pc = TABLE[i].cur;
         nxt_pc = TABLE[i].nxt;
         set_reqs(TABLE[i].req);
         #1 chk("R2 accepted event", 32'(accept), 32'(TABLE[i].win));
         @(negedge clk);
         set_reqs('0);
         chk("R5 busy in sequence", 32'(busy), 1);
         repeat (3) @(negedge clk);
         chk("R5 push count", n_push, 2);
         chk("R5 saved status pushed first", push_log[0], {16'h0, TABLE[i].saved});
         chk("R4 return address", push_log[1], TABLE[i].addr);
         chk("R6 vector index", 32'(vec_log), 32'(TABLE[i].vec));
         chk("R5 one vector strobe", n_vec, 1);
         chk("R7 R8 status after entry", 32'(psr), 32'(TABLE[i].psr_after));
         chk("R5 idle after sequence", 32'(busy), 0);
         chk("R5 stack grew by two", sp - sp0, 2);
      end

      // R3: maskable request ignored while I is clear
      begin
         int sp0;
         clear_logs();
         @(negedge clk);
         sp0 = sp;
         set_reqs(5'b01000);
         #1 chk("R3 masked irq not accepted", 32'(accept), 0);
         repeat (3) @(negedge clk);
         set_reqs('0);
         chk("R3 masked irq no busy", 32'(busy), 0);
         chk("R3 masked irq no push", n_push, 0);
         chk("R3 masked irq stack unchanged", sp - sp0, 0);
      end

      // R11: request raised only while busy is dropped without effect
      begin
         int sp0;
         clear_logs();
         @(negedge clk);
         sp0 = sp;
         cur_pc = 32'h700; nxt_pc = 32'h704;
         set_reqs(5'b00010);
         @(negedge clk);
         set_reqs(5'b00001);
         #1 chk("R11 no accept while busy", 32'(accept), 0);
         @(negedge clk);
         @(negedge clk);
         set_reqs('0);
         repeat (3) @(negedge clk);
         chk("R11 single frame", sp - sp0, 2);
         chk("R11 single vector", n_vec, 1);
         chk("R11 vector of svc", 32'(vec_log), 2);
         chk("R4 svc pushes current pc", push_log[1], 32'h700);
      end

      do_rett(32'h0700, 16'h0000);
      do_rett(32'h0604, 16'h0000);
      do_rett(32'h0504, 16'h0010);   // R10: I comes back to 1

      // R1: reset returns to idle mid-sequence and clears status
      @(negedge clk);
      cur_pc = 32'h800; nxt_pc = 32'h804;
      set_reqs(5'b00001);
      @(negedge clk);
      set_reqs('0);
      rst = 1;
      @(negedge clk);
      rst = 0;
      chk("R1 reset mid-sequence idle", {busy, push_en, vec_valid}, 0);
      chk("R1 reset clears status", 32'(psr), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule